// File: doc/BRIEF.md
# Serial-Probe Pseudo-Associative Read Cache

This block turns one direct-mapped line array into a cache that behaves like a set-associative one. Associativity comes from searching the ways one after another, not from parallel comparators. The array holds `LINES` lines, grouped as `LINES/WAYS` sets. The array slot for way `w` of a set is the way number placed above the set index, `{w, set}`. One tag comparator looks at one slot per clock cycle.

A requester presents a block address when the block is idle. The controller then probes way 0, way 1 and so on, and stops at the first matching line. When every way misses, it asks the next memory level for the block and writes the returned line into a chosen way. It then returns the data. The response gives a hit flag, the line data and the number of probes spent, so a hit late in the search is visible as longer latency.

The block accepts one request at a time. It takes no new request until the current one has been answered.

Top module: `pacache_top`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req` are 0. Every line is invalid, so the first access to any address misses.
- R2: The set is `req_addr[SET_W-1:0]` and the stored tag is all remaining upper address bits. A line matches only a request with the same set and identical upper bits, whichever way slot holds it.
- R3: Probes visit ways in the order 0, 1, ..., WAYS-1, each at array slot `{way, set}`. A hit in way k reports `rsp_probes` = k+1.
- R4: The search stops at the first hit and raises no `mem_req`. `rsp_valid` is high exactly `rsp_probes` rising edges after the edge that accepted the request.
- R5: After WAYS missing probes, `mem_req` rises with `mem_addr` equal to the request address. Both stay unchanged until `mem_valid`. The response then has `rsp_hit`=0, `rsp_probes`=WAYS and `rsp_data` equal to the returned `mem_data`.
- R6: A refill goes to the lowest-numbered invalid way of the set when one exists.
- R7: When all ways of the set are valid, a per-set rotation counter chooses the way. The counter is 0 after reset and advances by one, modulo WAYS, after each eviction in its own set only.
- R8: `req_ready` is high only while idle. A `req_valid` raised while not ready is ignored: it produces no extra response, no memory request and no change to the cache contents.
- R9: `rsp_valid` is a single-cycle pulse, and `req_ready` is high in the cycle after it.
- R10: Data returned on a hit equals the data that was filled for that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Block address of the request |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | 1 when the line was found in the array |
| rsp_data | output | DATA_W | Line data |
| rsp_probes | output | PRB_W | Number of array probes spent |
| mem_req | output | 1 | Refill request to next level |
| mem_addr | output | ADDR_W | Block address being refilled |
| mem_valid | input | 1 | Refill data present |
| mem_data | input | DATA_W | Refill line data |

## Verification
A wrong tag or valid bit in the array appears on the very next access to that set. It shows up as a false hit, a false miss or a wrong probe count in the response. A fault in the rotation counter stays hidden until a set is full. It then shows as an unexpected probe count, or as a miss on a line that should have survived, one or two accesses after the eviction. For this reason the bench keeps a full associative model of every set and compares every single response against it. Sequencer faults show up in the latency counted from the accepting edge.

// File: rtl/pacache_pkg.sv
package pacache_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_PROBE,
      SEQ_REFILL,
      SEQ_RESPOND
   } seq_state_e;
endpackage

// File: rtl/pacache_lines.sv
module pacache_lines #(
   parameter int LINES  = 64,
   parameter int WAYS   = 4,
   parameter int SETS   = 16,
   parameter int SET_W  = 4,
   parameter int IDX_W  = 6,
   parameter int TAG_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic              rd_valid_o,
   output logic [TAG_W-1:0]  rd_tag_o,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic [SET_W-1:0]  set_i,
   output logic [WAYS-1:0]   set_valid_o,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [TAG_W-1:0]  wr_tag_i,
   input  logic [DATA_W-1:0] wr_data_i
);
   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_mem  [LINES];
   logic [DATA_W-1:0] data_mem [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en_i) begin
         valid_q[wr_idx_i] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en_i) begin
         tag_mem[wr_idx_i]  <= wr_tag_i;
         data_mem[wr_idx_i] <= wr_data_i;
      end
   end

   assign rd_valid_o = valid_q[rd_idx_i];
   assign rd_tag_o   = tag_mem[rd_idx_i];
   assign rd_data_o  = data_mem[rd_idx_i];

   // valid bits of every way slot belonging to one set, for the victim choice
   for (genvar w = 0; w < WAYS; w++) begin : g_setv
      assign set_valid_o[w] = valid_q[IDX_W'(w * SETS) + IDX_W'(set_i)];
   end
endmodule

// File: rtl/pacache_victim.sv
module pacache_victim #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   parameter int SET_W = 4,
   parameter int WAY_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_i,
   input  logic [WAYS-1:0]  way_valid_i,
   input  logic             fill_i,
   output logic [WAY_W-1:0] victim_o
);
   if (WAYS == 1) begin : g_direct
      assign victim_o = '0;
   end else begin : g_rotate
      logic [WAY_W-1:0] rr_q [SETS];
      logic             any_free;
      logic [WAY_W-1:0] free_way;

      // lowest-numbered empty way wins
      always_comb begin
         any_free = 1'b0;
         free_way = '0;
         for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid_i[w]) begin
               any_free = 1'b1;
               free_way = WAY_W'(w);
            end
         end
      end

      assign victim_o = any_free ? free_way : rr_q[set_i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
         end else if (fill_i && !any_free) begin
            rr_q[set_i] <= rr_q[set_i] + WAY_W'(1);
         end
      end
   end
endmodule

// File: rtl/pacache_top.sv
module pacache_top
   import pacache_pkg::*;
#(
   parameter int LINES  = 64,
   parameter int WAYS   = 4,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int PRB_W  = $clog2(WAYS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [DATA_W-1:0] rsp_data,
   output logic [PRB_W-1:0]  rsp_probes,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_data
);
   localparam int SETS  = LINES / WAYS;
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - SET_W;

   if (WAYS < 1 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two");
   end
   if ((LINES % WAYS) != 0 || SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_lines
      $error("LINES/WAYS must be a power of two of at least 2");
   end
   if (ADDR_W <= SET_W) begin : g_bad_addr
      $error("ADDR_W must exceed the set index width");
   end
   if (PRB_W < $clog2(WAYS + 1)) begin : g_bad_prb
      $error("PRB_W too narrow for the probe count");
   end

   seq_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WAY_W-1:0]  way_q;
   logic [DATA_W-1:0] data_q;
   logic              hit_q;
   logic [PRB_W-1:0]  prb_q;

   logic [SET_W-1:0]  set_w;
   logic [TAG_W-1:0]  tag_w;
   logic [IDX_W-1:0]  probe_idx;
   logic [IDX_W-1:0]  fill_idx;
   logic              rd_valid;
   logic [TAG_W-1:0]  rd_tag;
   logic [DATA_W-1:0] rd_data;
   logic [WAYS-1:0]   set_valid;
   logic [WAY_W-1:0]  victim;
   logic              probe_hit;
   logic              last_way;
   logic              fill_en;

   assign set_w     = addr_q[SET_W-1:0];
   assign tag_w     = addr_q[ADDR_W-1:SET_W];
   assign probe_idx = IDX_W'({way_q, set_w});
   assign fill_idx  = IDX_W'({victim, set_w});
   assign probe_hit = rd_valid && (rd_tag == tag_w);
   assign last_way  = (way_q == WAY_W'(WAYS - 1));
   assign fill_en   = (state_q == SEQ_REFILL) && mem_valid;

   pacache_lines #(
      .LINES (LINES),
      .WAYS  (WAYS),
      .SETS  (SETS),
      .SET_W (SET_W),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
   ) u_lines (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx_i   (probe_idx),
      .rd_valid_o (rd_valid),
      .rd_tag_o   (rd_tag),
      .rd_data_o  (rd_data),
      .set_i      (set_w),
      .set_valid_o(set_valid),
      .wr_en_i    (fill_en),
      .wr_idx_i   (fill_idx),
      .wr_tag_i   (tag_w),
      .wr_data_i  (mem_data)
   );

   pacache_victim #(
      .SETS (SETS),
      .WAYS (WAYS),
      .SET_W(SET_W),
      .WAY_W(WAY_W)
   ) u_victim (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_w),
      .way_valid_i(set_valid),
      .fill_i     (fill_en),
      .victim_o   (victim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         addr_q  <= '0;
         way_q   <= '0;
         data_q  <= '0;
         hit_q   <= 1'b0;
         prb_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (req_valid) begin
                  addr_q  <= req_addr;
                  way_q   <= '0;
                  state_q <= SEQ_PROBE;
               end
            end
            SEQ_PROBE: begin
               if (probe_hit) begin
                  data_q  <= rd_data;
                  hit_q   <= 1'b1;
                  prb_q   <= PRB_W'(way_q) + PRB_W'(1);
                  state_q <= SEQ_RESPOND;
               end else if (last_way) begin
                  state_q <= SEQ_REFILL;
               end else begin
                  way_q <= way_q + WAY_W'(1);
               end
            end
            SEQ_REFILL: begin
               if (mem_valid) begin
                  data_q  <= mem_data;
                  hit_q   <= 1'b0;
                  prb_q   <= PRB_W'(WAYS);
                  state_q <= SEQ_RESPOND;
               end
            end
            SEQ_RESPOND: begin
               state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == SEQ_IDLE);
   assign rsp_valid  = (state_q == SEQ_RESPOND);
   assign rsp_hit    = hit_q;
   assign rsp_data   = data_q;
   assign rsp_probes = prb_q;
   assign mem_req    = (state_q == SEQ_REFILL);
   assign mem_addr   = addr_q;
endmodule

// File: rtl/pacache_top_chk.sv
module pacache_top_chk #(
   parameter int WAYS   = 4,
   parameter int ADDR_W = 12,
   parameter int PRB_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic [PRB_W-1:0]  rsp_probes,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_valid
);
   AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);  // R8
   AST_IDLE_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req && !rsp_valid);  // R8
   AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready);  // R9
   AST_PROBE_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_probes >= PRB_W'(1)) && (rsp_probes <= PRB_W'(WAYS)));  // R3
   AST_MISS_USES_ALL_WAYS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_hit |-> rsp_probes == PRB_W'(WAYS));  // R5
   AST_REFILL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_valid |=> mem_req && $stable(mem_addr));  // R5
endmodule

bind pacache_top pacache_top_chk #(
   .WAYS  (WAYS),
   .ADDR_W(ADDR_W),
   .PRB_W (PRB_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_probes(rsp_probes),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_valid (mem_valid)
);

// File: tb/pacache_top_bench.sv
`timescale 1ns/1ps
module pacache_top_bench;
   localparam int LINES  = 64;
   localparam int WAYS   = 4;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;
   localparam int PRB_W  = 3;
   localparam int SETS   = LINES / WAYS;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic              req_ready;
   logic              rsp_valid;
   logic              rsp_hit;
   logic [DATA_W-1:0] rsp_data;
   logic [PRB_W-1:0]  rsp_probes;
   logic              mem_req;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_valid = 1'b0;
   logic [DATA_W-1:0] mem_data;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pacache_top #(
      .LINES(LINES), .WAYS(WAYS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRB_W(PRB_W)
   ) u_pacache_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_data(rsp_data), .rsp_probes(rsp_probes), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
   );

   function automatic logic [DATA_W-1:0] line_of(input logic [ADDR_W-1:0] a);
      return {4'hA, a, ~a[7:0], a[11:4]};
   endfunction

   assign mem_data = line_of(mem_addr);

   // next-level memory: answers after three negative edges of a held request
   int mem_wait = 0;
   always @(negedge clk) begin
      if (mem_req) begin
         if (mem_wait >= 2) mem_valid = 1'b1;
         else mem_wait++;
      end else begin
         mem_wait  = 0;
         mem_valid = 1'b0;
      end
   end

   // associative reference model
   bit         m_v [SETS][WAYS];
   logic [7:0] m_t [SETS][WAYS];
   int         m_rr[SETS];

   task automatic check(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_access(input logic [ADDR_W-1:0] a, output bit hit, output int probes);
      int s;
      int v;
      s = int'(a[3:0]);
      hit = 1'b0;
      probes = WAYS;
      for (int w = 0; w < WAYS; w++) begin
         if (!hit && m_v[s][w] && m_t[s][w] == a[11:4]) begin
            hit = 1'b1;
            probes = w + 1;
         end
      end
      if (!hit) begin
         v = -1;
         for (int w = WAYS - 1; w >= 0; w--) if (!m_v[s][w]) v = w;
         if (v < 0) begin
            v = m_rr[s];
            m_rr[s] = (m_rr[s] + 1) % WAYS;
         end
         m_v[s][v] = 1'b1;
         m_t[s][v] = a[11:4];
      end
   endtask

   task automatic access(input logic [ADDR_W-1:0] a, input string req, input bit poke,
                         output int got_probes);
      bit eh;
      int ep;
      int cyc;
      bit seen;
      logic [ADDR_W-1:0] maddr;
      bit got_hit;
      logic [DATA_W-1:0] got_data;
      model_access(a, eh, ep);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         req_valid = 1'b1;
         req_addr  = a ^ 12'h0F0;
      end
      cyc = 0;
      seen = 1'b0;
      maddr = '0;
      while (1) begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         req_valid = 1'b0;
         if (mem_req) begin
            seen  = 1'b1;
            maddr = mem_addr;
         end
         if (rsp_valid || cyc > 200) break;
      end
      got_hit    = rsp_hit;
      got_data   = rsp_data;
      got_probes = int'(rsp_probes);
      check(req, "response present", int'(rsp_valid), 1);
      check(req, "hit flag", int'(got_hit), int'(eh));
      check(req, "probe count", got_probes, ep);
      if (eh) begin
         check("R10", "hit data", int'(got_data), int'(line_of(a)));
         check("R4", "latency equals probes", cyc, ep);
         check("R4", "no refill on hit", int'(seen), 0);
      end else begin
         check("R5", "refill data", int'(got_data), int'(line_of(a)));
         check("R5", "refill address", int'(maddr), int'(a));
         check("R5", "refill after all probes", int'(cyc > WAYS), 1);
      end
      @(negedge clk);
      check("R9", "response pulse ended", int'(rsp_valid), 0);
      check("R9", "ready after response", int'(req_ready), 1);
   endtask

   task automatic t_reset();
      int p;
      check("R1", "ready after reset", int'(req_ready), 1);
      check("R1", "no response after reset", int'(rsp_valid), 0);
      check("R1", "no refill after reset", int'(mem_req), 0);
      access(12'h123, "R1", 1'b0, p);
      check("R1", "cold access misses", p, WAYS);
   endtask

   task automatic t_repeat_hit();
      int p;
      access(12'h123, "R4", 1'b0, p);
      check("R4", "rehit in way 0", p, 1);
   endtask

   task automatic t_fill_order();
      int p;
      for (int t = 1; t <= WAYS; t++) begin
         access({8'(t), 4'h5}, "R6", 1'b0, p);
      end
      for (int t = WAYS; t >= 1; t--) begin
         access({8'(t), 4'h5}, "R3", 1'b0, p);
         check("R3", "way order of fill", p, t);
      end
   endtask

   task automatic t_alias();
      int p;
      access({8'h01, 4'h6}, "R2", 1'b0, p);
      check("R2", "same tag other set misses", p, WAYS);
      access({8'h11, 4'h5}, "R2", 1'b0, p);
      check("R2", "upper tag bit differs misses", p, WAYS);
   endtask

   task automatic t_rotation();
      int p;
      access({8'h09, 4'h5}, "R7", 1'b0, p);
      access({8'h09, 4'h5}, "R7", 1'b0, p);
      check("R7", "rotation fill lands in way", p, 2);
      access({8'h0A, 4'h5}, "R7", 1'b0, p);
      access({8'h0A, 4'h5}, "R7", 1'b0, p);
      check("R7", "rotation advances", p, 3);
      for (int t = 2; t <= WAYS; t++) access({8'(t), 4'h6}, "R6", 1'b0, p);
      access({8'h07, 4'h6}, "R7", 1'b0, p);
      access({8'h07, 4'h6}, "R7", 1'b0, p);
      check("R7", "other set counter independent", p, 1);
   endtask

   task automatic t_busy();
      int p;
      access(12'hA5C, "R8", 1'b1, p);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check("R8", "no extra response", int'(rsp_valid), 0);
         check("R8", "no extra refill", int'(mem_req), 0);
      end
      access(12'hAAC, "R8", 1'b0, p);
      check("R8", "ignored address not installed", p, WAYS);
   endtask

   task automatic t_sweep();
      int p;
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 250; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         access({5'b0, lf[5:3], 2'b10, lf[1:0]}, "R7", 1'b0, p);
      end
   endtask

   initial begin
      for (int s = 0; s < SETS; s++) begin
         m_rr[s] = 0;
         for (int w = 0; w < WAYS; w++) begin
            m_v[s][w] = 1'b0;
            m_t[s][w] = '0;
         end
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_repeat_hit();
      t_fill_order();
      t_alias();
      t_rotation();
      t_busy();
      t_sweep();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule